// File: doc/BRIEF.md
# Paired Edge Capture Channel

This block takes two timestamps from one timer input. It watches a filtered input pin against a free-running counter and copies the counter into two capture registers on two edges that can be chosen separately. A first-stage edge loads the first register. The next qualifying second-stage edge loads the second register. The difference between the two values is a period or a pulse width, depending on which edges are selected.

Software starts a measurement by pulsing an arm command. In one-shot mode the arm state drops by itself when the second timestamp is taken. Software then knows the pair is complete when the arm state is low and the second flag is high. In continuous mode the arm state stays high and the pair keeps being refreshed on later edges. Each capture sets its own flag. Only a software clear pulse clears a flag.

Top module: `edge_pair_capture`

## Requirements
- R1: After reset, both capture registers, both flags and the arm state read zero.
- R2: Captures happen only while `pairEn` is 1 and the arm state is 1. While `pairEn` is 0, the measurement returns to its first stage.
- R3: In the first stage, an edge that matches `edgeSelA` loads `cntVal` into `capA`, sets `flagA`, and moves to the second stage.
- R4: In the second stage, an edge that matches `edgeSelB` loads `cntVal` into `capB`, sets `flagB`, and moves back to the first stage.
- R5: In one-shot mode (`contMode` = 0), the arm state drops to 0 in the same clock edge that takes the second capture.
- R6: In continuous mode (`contMode` = 1), the arm state stays 1 after a second capture, and later edges start new capture pairs.
- R7: The edge-select encoding is 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 either edge. `chanIn` passes through two synchronizing flops and is then compared with its previous sample. A capture therefore stores the `cntVal` value present at the third rising clock edge after `chanIn` changes.
- R8: A flag clears only on its clear pulse. If a capture and a clear of the same flag fall on one cycle, the flag stays set.
- R9: A second-stage edge counts only after the first capture of the current measurement. An edge that matches both selects fires only the stage that is pending.
- R10: An `armSet` pulse sets the arm state and restarts the measurement at the first stage. An edge in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntVal | input | CNT_W | Free-running counter value |
| chanIn | input | 1 | Filtered channel input (asynchronous) |
| pairEn | input | 1 | Dual-edge capture enable |
| contMode | input | 1 | 1 = continuous, 0 = one-shot |
| edgeSelA | input | 2 | Edge select for the first capture |
| edgeSelB | input | 2 | Edge select for the second capture |
| armSet | input | 1 | Pulse that arms and restarts a measurement |
| clrFlagA | input | 1 | Pulse that clears flagA |
| clrFlagB | input | 1 | Pulse that clears flagB |
| capA | output | CNT_W | First capture value |
| capB | output | CNT_W | Second capture value |
| flagA | output | 1 | First capture event flag |
| flagB | output | 1 | Second capture event flag |
| armed | output | 1 | Arm state |

## Verification
Some properties are checked on every cycle:
- the two capture strobes never fire together;
- the arm state rises only after an arm pulse;
- a one-shot second capture leaves the channel disarmed;
- a flag never drops without its clear pulse;
- a capture register changes only on its strobe.

Other behaviour needs the bench's waveforms and a cycle-accurate model:
- the measured differences for period, pulse width and either-edge selections;
- the synchronizer latency;
- restart on re-arm;
- an edge matching both selects firing only the pending stage;
- continuous refresh.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edgeSel_e;

  typedef struct packed {
    logic takeFirst;
    logic takeSecond;
  } capStrobe_t;

  function automatic logic edgeMatch(input logic [1:0] sel, input logic rise, input logic fall);
    case (sel)
      EDGE_RISE: edgeMatch = rise;
      EDGE_FALL: edgeMatch = fall;
      EDGE_ANY:  edgeMatch = rise | fall;
      default:   edgeMatch = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pcap_ctrl.sv
module pcap_ctrl
  import pcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       chanIn,
  input  logic       pairEn,
  input  logic       contMode,
  input  logic [1:0] edgeSelA,
  input  logic [1:0] edgeSelB,
  input  logic       armSet,
  input  logic       clrFlagA,
  input  logic       clrFlagB,
  output capStrobe_t strobe,
  output logic       flagA,
  output logic       flagB,
  output logic       armed
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          prevQ;
  logic          riseEv, fallEv;
  logic          inSecond;
  logic          hitA, hitB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[LAST-1:0], chanIn};
      prevQ <= syncQ[LAST];
    end
  end

  assign riseEv = syncQ[LAST] & ~prevQ;
  assign fallEv = ~syncQ[LAST] & prevQ;
  assign hitA   = edgeMatch(edgeSelA, riseEv, fallEv);
  assign hitB   = edgeMatch(edgeSelB, riseEv, fallEv);

  always_comb begin
    strobe = '0;
    if (!armSet && pairEn && armed) begin
      strobe.takeFirst  = !inSecond && hitA;
      strobe.takeSecond = inSecond && hitB;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      inSecond <= 1'b0;
    end else if (armSet) begin
      armed    <= 1'b1;
      inSecond <= 1'b0;
    end else if (!pairEn) begin
      inSecond <= 1'b0;
    end else if (strobe.takeFirst) begin
      inSecond <= 1'b1;
    end else if (strobe.takeSecond) begin
      inSecond <= 1'b0;
      if (!contMode) armed <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagA <= 1'b0;
      flagB <= 1'b0;
    end else begin
      if (strobe.takeFirst)  flagA <= 1'b1;
      else if (clrFlagA)     flagA <= 1'b0;
      if (strobe.takeSecond) flagB <= 1'b1;
      else if (clrFlagB)     flagB <= 1'b0;
    end
  end

  // R9: only one stage fires per cycle
  p_single_stage_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.takeFirst && strobe.takeSecond));
  // R10: arm state can only rise after an arm pulse
  p_arm_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    !armSet |=> !$rose(armed));
  // R5: one-shot second capture disarms
  p_oneshot_disarm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.takeSecond && !contMode) |=> !armed);
  // R8: flags fall only on a clear pulse
  p_flag_a_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagA && !clrFlagA) |=> flagA);
  p_flag_b_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagB && !clrFlagB) |=> flagB);
endmodule

// File: rtl/pcap_datapath.sv
module pcap_datapath
  import pcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  capStrobe_t       strobe,
  output logic [CNT_W-1:0] capA,
  output logic [CNT_W-1:0] capB
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capA <= '0;
      capB <= '0;
    end else begin
      if (strobe.takeFirst)  capA <= cntVal;
      if (strobe.takeSecond) capB <= cntVal;
    end
  end

  // R3: first register holds between first-stage strobes
  p_capa_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeFirst |=> $stable(capA));
  // R4: second register holds between second-stage strobes
  p_capb_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeSecond |=> $stable(capB));
  // R3: a first-stage strobe stores the sampled count
  p_capa_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeFirst |=> capA == $past(cntVal));
endmodule

// File: rtl/edge_pair_capture.sv
module edge_pair_capture
  import pcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             chanIn,
  input  logic             pairEn,
  input  logic             contMode,
  input  logic [1:0]       edgeSelA,
  input  logic [1:0]       edgeSelB,
  input  logic             armSet,
  input  logic             clrFlagA,
  input  logic             clrFlagB,
  output logic [CNT_W-1:0] capA,
  output logic [CNT_W-1:0] capB,
  output logic             flagA,
  output logic             flagB,
  output logic             armed
);
  capStrobe_t strobe;

  pcap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .pairEn(pairEn),
    .contMode(contMode), .edgeSelA(edgeSelA), .edgeSelB(edgeSelB),
    .armSet(armSet), .clrFlagA(clrFlagA), .clrFlagB(clrFlagB),
    .strobe(strobe), .flagA(flagA), .flagB(flagB), .armed(armed)
  );

  pcap_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .strobe(strobe),
    .capA(capA), .capB(capB)
  );
endmodule

// File: tb/edge_pair_capture_bench.sv
module edge_pair_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;

  logic clk = 0, rstN = 0;
  logic [CW-1:0] cntVal = '0;
  logic chanIn = 0, pairEn = 0, contMode = 0, armSet = 0, clrFlagA = 0, clrFlagB = 0;
  logic [1:0] edgeSelA = 2'b01, edgeSelB = 2'b01;
  logic [CW-1:0] capA, capB;
  logic flagA, flagB, armed;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  edge_pair_capture u_edge_pair_capture (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .chanIn(chanIn), .pairEn(pairEn),
    .contMode(contMode), .edgeSelA(edgeSelA), .edgeSelB(edgeSelB), .armSet(armSet),
    .clrFlagA(clrFlagA), .clrFlagB(clrFlagB), .capA(capA), .capB(capB),
    .flagA(flagA), .flagB(flagB), .armed(armed)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model
  int hist[$];
  int mA = 0, mB = 0;
  bit mFa = 0, mFb = 0, mArm = 0, mSecond = 0;

  function automatic bit selHit(input logic [1:0] s, input bit r, input bit f);
    return (s == 2'b01 && r) || (s == 2'b10 && f) || (s == 2'b11 && (r || f));
  endfunction

  always @(posedge clk) begin
    if (rstN) begin
      bit rise, fall, sA, sB;
      rise = hist[1] == 1 && hist[2] == 0;
      fall = hist[1] == 0 && hist[2] == 1;
      sA = 0; sB = 0;
      if (armSet) begin
        mArm = 1; mSecond = 0;
      end else if (!pairEn) begin
        mSecond = 0;
      end else if (mArm) begin
        if (!mSecond && selHit(edgeSelA, rise, fall)) begin
          sA = 1; mA = int'(cntVal); mSecond = 1;
        end else if (mSecond && selHit(edgeSelB, rise, fall)) begin
          sB = 1; mB = int'(cntVal); mSecond = 0;
          if (!contMode) mArm = 0;
        end
      end
      if (sA) mFa = 1; else if (clrFlagA) mFa = 0;
      if (sB) mFb = 1; else if (clrFlagB) mFb = 0;
      hist.push_front(int'(chanIn));
      void'(hist.pop_back());
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(int'(capA) == mA, "R3 capA", int'(capA), mA);
      chk(int'(capB) == mB, "R4 capB", int'(capB), mB);
      chk(flagA == mFa, "R8 flagA", int'(flagA), int'(mFa));
      chk(flagB == mFb, "R8 flagB", int'(flagB), int'(mFb));
      chk(armed == mArm, "R5 armed", int'(armed), int'(mArm));
    end
  end

  always @(negedge clk) cntVal <= cntVal + 1'b1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    chanIn = 1; tick(hi);
    chanIn = 0; tick(lo);
  endtask

  task automatic arm();
    armSet = 1; tick(1); armSet = 0;
  endtask

  task automatic clearFlags();
    clrFlagA = 1; clrFlagB = 1; tick(1); clrFlagA = 0; clrFlagB = 0;
  endtask

  initial begin
    hist = '{0, 0, 0};
    tick(3);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(capA == 0 && capB == 0, "R1 caps", int'(capA), 0);
    chk(!flagA && !flagB && !armed, "R1 flags", int'({flagA, flagB, armed}), 0);

    // R2 disabled: no capture
    arm(); pulse(5, 5); pulse(5, 5);
    chk(!flagA && !flagB, "R2 no capture when disabled", int'({flagA, flagB}), 0);
    pairEn = 1; contMode = 0;

    // R3/R4/R5 one-shot period, rising/rising
    edgeSelA = 2'b01; edgeSelB = 2'b01;
    arm(); pulse(10, 10); pulse(10, 10); pulse(10, 10);
    chk(flagA && flagB, "R4 both flags", int'({flagA, flagB}), 3);
    chk(!armed, "R5 disarmed", int'(armed), 0);
    chk(int'(capB - capA) == 20, "R3 period", int'(capB - capA), 20);

    clearFlags();
    chk(!flagA && !flagB, "R8 cleared", int'({flagA, flagB}), 0);

    // R7 pulse width rising/falling, latency
    edgeSelB = 2'b10;
    arm(); tick(2);
    begin
      int expA;
      chanIn = 1;
      expA = int'(cntVal) + 3;
      tick(7); chanIn = 0; tick(13);
      chk(int'(capA) == expA, "R7 latency", int'(capA), expA);
    end
    chk(int'(capB - capA) == 7, "R7 width", int'(capB - capA), 7);

    // R7 either/either, R9 pending stage only
    clearFlags();
    edgeSelA = 2'b11; edgeSelB = 2'b11;
    arm(); chanIn = 1; tick(6);
    chk(flagA && !flagB, "R9 only pending stage", int'({flagA, flagB}), 2);
    chanIn = 0; tick(6);
    chk(int'(capB - capA) == 6, "R7 either edges", int'(capB - capA), 6);

    // R7 disabled select
    clearFlags();
    edgeSelA = 2'b00;
    arm(); pulse(4, 4); pulse(4, 4);
    chk(!flagA, "R7 select off", int'(flagA), 0);

    // R10 restart
    edgeSelA = 2'b01; edgeSelB = 2'b01;
    arm(); pulse(5, 5);
    begin
      int firstA;
      firstA = int'(capA);
      clearFlags(); arm(); pulse(5, 5);
      chk(capA != firstA[CW-1:0] && !flagB, "R10 restart at first stage", int'(flagB), 0);
    end

    // R8 set wins over clear
    clearFlags(); arm();
    begin
      bit seen;
      seen = 0;
      clrFlagA = 1; chanIn = 1;
      for (int i = 0; i < 6; i++) begin
        tick(1);
        if (flagA) seen = 1;
      end
      clrFlagA = 0;
      chk(seen, "R8 set wins", int'(seen), 1);
    end
    chanIn = 0; tick(6);

    // R6 continuous
    contMode = 1; clearFlags(); arm();
    begin
      int a1;
      pulse(8, 8); pulse(8, 8);
      a1 = int'(capA);
      pulse(8, 8); pulse(8, 8);
      chk(armed, "R6 stays armed", int'(armed), 1);
      chk(int'(capB - capA) == 16, "R6 period", int'(capB - capA), 16);
      chk(int'(capA) != a1, "R6 refreshed", int'(capA), a1 + 32);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule